// File: doc/BRIEF.md
# Page Write Buffer and Write-Cycle Sequencer

This block sits behind the serial protocol engine of a two-wire EEPROM slave. It gathers the data bytes of one write command into a page-sized latch and wraps the byte address inside the page. When the command is closed by STOP in the right slot, it runs an internal write cycle. During that cycle it copies the received bytes into the memory array through a write port and holds a busy flag. The protocol engine uses that flag to ignore the bus, so a master that polls with select bytes gets no acknowledge until the cycle ends.

The protocol engine supplies single-cycle event strobes: START, STOP, an accepted write select, an address load, one tick per received data bit, and a data-byte-acknowledged strobe that carries the byte. The write time is a parameter counted in system clocks. The default covers 5 ms at 100 MHz, and a test can set a short value. When the cycle ends, the block reports the next value of the address counter to the engine.

Top module: `page_write_sequencer`

## Requirements
- R1: While reset is held, and just after it is released, `busy_o`, `mem_we_o` and `cnt_upd_o` are low.
- R2: A data byte strobed by `byte_wr_i` is accepted only inside a write command, after the address load. It is stored at the current in-page offset, and the offset then increments by one.
- R3: The page is the upper address bits `addr[10:4]` and the offset is `addr[3:0]`. After offset 15 the offset returns to 0 of the same page. A later byte at an offset replaces the earlier one, and every commit write carries the page of the command.
- R4: A write cycle starts only when `stop_i` arrives with no `bit_tick_i` and no `start_i` since the last accepted data byte. A STOP after a bit tick, or after a repeated START, starts no write.
- R5: A write command that carries only an address and no data byte never starts a write cycle.
- R6: `busy_o` rises on the cycle after the launching STOP and stays high for exactly `WR_CLKS` cycles. `mem_we_o` is asserted only while `busy_o` is high.
- R7: While `busy_o` is high, every event input is ignored. This traffic causes no extra write, no change to `cnt_val_o`, and no new write cycle once busy ends.
- R8: `cnt_upd_o` pulses once, in the last busy cycle. At that time `cnt_val_o = {page, offset after the last received byte}`, with the offset wrapping inside the page.
- R9: Only offsets that received a byte are written, one per cycle, in ascending offset order. Each write uses `mem_addr_o = {page, offset}` and carries the latest byte for that offset. Offsets that received no byte are not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | START or repeated START seen (one-cycle strobe) |
| stop_i | input | 1 | STOP seen (one-cycle strobe) |
| wsel_i | input | 1 | Write select byte accepted (one-cycle strobe) |
| addr_load_i | input | 1 | Byte address complete (one-cycle strobe) |
| addr_i | input | ADDR_W | Full byte address, valid with `addr_load_i` |
| bit_tick_i | input | 1 | One received bit of the next byte (one-cycle strobe) |
| byte_wr_i | input | 1 | Data byte acknowledged (one-cycle strobe) |
| wbyte_i | input | 8 | Data byte, valid with `byte_wr_i` |
| busy_o | output | 1 | Internal write cycle running; engine must ignore the bus |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | 8 | Array write data |
| cnt_upd_o | output | 1 | Address counter update strobe |
| cnt_val_o | output | ADDR_W | New address counter value |

## Verification
The bench targets page wraparound at offsets 14 and 15, and an 18-byte burst that wraps onto its own first bytes. If the wrap were done wrongly, the commit would leave the page or write stale data to offsets 0 and 1. It closes commands with STOP after a stray bit tick, after a repeated START, and after an address-only select. A sequencer that armed on any STOP would start a busy period and write unexpected bytes. It also injects a complete write command while the cycle is running. A design that failed to gate its inputs would commit a second page or change the reported counter. The scoreboard checks the busy length and the counter value at the update strobe, which catches off-by-one errors in the timer and in the offset.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

  // Phases of the internal write cycle.
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_COMMIT = 2'd1,
    SEQ_HOLD   = 2'd2
  } seq_state_e;

endpackage

// File: rtl/wpb_cmd_track.sv
// Follows one write command: select, address, data bytes, arming for STOP.
module wpb_cmd_track #(
  parameter int ADDR_W = 11,
  parameter int OFS_W  = 4,
  localparam int PG_W  = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wsel_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bit_tick_i,
  input  logic              byte_wr_i,
  output logic [PG_W-1:0]   page_o,
  output logic [OFS_W-1:0]  ofs_o,
  output logic              accept_o,
  output logic              launch_o,
  output logic              new_cmd_o
);

  logic             cmd_q, cmd_n;
  logic             adr_q, adr_n;
  logic             arm_q, arm_n;
  logic [PG_W-1:0]  page_q;
  logic [OFS_W-1:0] ofs_q;
  logic             ld_en, inc_en;

  // An event is seen only when no write cycle runs.
  logic idle, frame_end, sel_ev, ld_ev;
  assign idle      = !busy_i;
  assign frame_end = idle && (start_i || stop_i);
  assign sel_ev    = idle && !frame_end && wsel_i;
  assign ld_ev     = idle && !frame_end && !sel_ev && addr_load_i && cmd_q;
  assign accept_o  = idle && !frame_end && !sel_ev && !addr_load_i &&
                     byte_wr_i && cmd_q && adr_q;
  assign launch_o  = idle && stop_i && arm_q;
  assign new_cmd_o = sel_ev;

  assign ld_en  = ld_ev;
  assign inc_en = accept_o;

  always_comb begin
    cmd_n = cmd_q;
    adr_n = adr_q;
    arm_n = arm_q;
    if (frame_end) begin
      cmd_n = 1'b0;
      adr_n = 1'b0;
      arm_n = 1'b0;
    end else if (sel_ev) begin
      cmd_n = 1'b1;
      adr_n = 1'b0;
      arm_n = 1'b0;
    end else if (ld_ev) begin
      adr_n = 1'b1;
      arm_n = 1'b0;
    end else if (accept_o) begin
      arm_n = 1'b1;
    end else if (idle && bit_tick_i) begin
      arm_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= 1'b0;
      adr_q <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      cmd_q <= cmd_n;
      adr_q <= adr_n;
      arm_q <= arm_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
    end else if (ld_en) begin
      page_q <= addr_i[ADDR_W-1:OFS_W];
    end
  end

  // Offset wraps inside the page by its own width.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0;
    end else if (ld_en) begin
      ofs_q <= addr_i[OFS_W-1:0];
    end else if (inc_en) begin
      ofs_q <= ofs_q + 1'b1;
    end
  end

  assign page_o = page_q;
  assign ofs_o  = ofs_q;

endmodule

// File: rtl/wpb_page_latch.sv
// Page-sized byte latch with a per-byte valid mask.
module wpb_page_latch #(
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [OFS_W-1:0]  wofs_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [OFS_W-1:0]  rofs_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvld_o
);

  logic [DATA_W-1:0]     data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
    logic hit;
    assign hit = wr_i && (wofs_i == OFS_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
      end else if (clr_i) begin
        vld_q[g] <= 1'b0;
      end else if (hit) begin
        vld_q[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[g] <= '0;
      end else if (hit) begin
        data_q[g] <= wdata_i;
      end
    end
  end

  assign rdata_o = data_q[rofs_i];
  assign rvld_o  = vld_q[rofs_i];

endmodule

// File: rtl/wpb_cycle_seq.sv
// Internal write cycle: scan-and-commit phase, then hold until the write time ends.
module wpb_cycle_seq
  import wpb_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int WR_CLKS    = 500000,
  localparam int OFS_W     = $clog2(PAGE_BYTES),
  localparam int TMR_W     = $clog2(WR_CLKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_i,
  output logic             busy_o,
  output logic             scan_act_o,
  output logic [OFS_W-1:0] scan_ofs_o,
  output logic             done_o
);

  localparam logic [TMR_W-1:0] TMR_LAST  = TMR_W'(WR_CLKS - 1);
  localparam logic [OFS_W-1:0] SCAN_LAST = OFS_W'(PAGE_BYTES - 1);

  seq_state_e       state_q, state_n;
  logic [TMR_W-1:0] tmr_q, tmr_n;
  logic [OFS_W-1:0] scan_q, scan_n;
  logic             tmr_en, scan_en;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      SEQ_IDLE:   if (launch_i)             state_n = SEQ_COMMIT;
      SEQ_COMMIT: if (scan_q == SCAN_LAST)  state_n = SEQ_HOLD;
      SEQ_HOLD:   if (tmr_q == TMR_LAST)    state_n = SEQ_IDLE;
      default:                              state_n = SEQ_IDLE;
    endcase
  end

  assign tmr_en  = (state_q != SEQ_IDLE) || launch_i;
  assign tmr_n   = (state_q == SEQ_IDLE) ? '0 : tmr_q + 1'b1;
  assign scan_en = (state_q == SEQ_COMMIT) || (state_q == SEQ_IDLE && launch_i);
  assign scan_n  = (state_q == SEQ_IDLE) ? '0 : scan_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else begin
      state_q <= state_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else if (tmr_en) begin
      tmr_q <= tmr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_q <= '0;
    end else if (scan_en) begin
      scan_q <= scan_n;
    end
  end

  assign busy_o     = (state_q != SEQ_IDLE);
  assign scan_act_o = (state_q == SEQ_COMMIT);
  assign scan_ofs_o = scan_q;
  assign done_o     = (state_q == SEQ_HOLD) && (tmr_q == TMR_LAST);

endmodule

// File: rtl/page_write_sequencer.sv
// Top: page write buffer plus write-cycle sequencer.
module page_write_sequencer #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CLKS    = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wsel_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bit_tick_i,
  input  logic              byte_wr_i,
  input  logic [7:0]        wbyte_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              cnt_upd_o,
  output logic [ADDR_W-1:0] cnt_val_o
);

  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFS_W;

  logic [PG_W-1:0]  page;
  logic [OFS_W-1:0] ofs;
  logic             accept, launch, new_cmd;
  logic             busy, scan_act, done;
  logic [OFS_W-1:0] scan_ofs;
  logic [7:0]       rdata;
  logic             rvld;

  wpb_cmd_track #(
    .ADDR_W (ADDR_W),
    .OFS_W  (OFS_W)
  ) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_i      (busy),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .wsel_i      (wsel_i),
    .addr_load_i (addr_load_i),
    .addr_i      (addr_i),
    .bit_tick_i  (bit_tick_i),
    .byte_wr_i   (byte_wr_i),
    .page_o      (page),
    .ofs_o       (ofs),
    .accept_o    (accept),
    .launch_o    (launch),
    .new_cmd_o   (new_cmd)
  );

  wpb_page_latch #(
    .PAGE_BYTES (PAGE_BYTES),
    .DATA_W     (8)
  ) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (new_cmd || done),
    .wr_i    (accept),
    .wofs_i  (ofs),
    .wdata_i (wbyte_i),
    .rofs_i  (scan_ofs),
    .rdata_o (rdata),
    .rvld_o  (rvld)
  );

  wpb_cycle_seq #(
    .PAGE_BYTES (PAGE_BYTES),
    .WR_CLKS    (WR_CLKS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch_i   (launch),
    .busy_o     (busy),
    .scan_act_o (scan_act),
    .scan_ofs_o (scan_ofs),
    .done_o     (done)
  );

  assign busy_o      = busy;
  assign mem_we_o    = scan_act && rvld;
  assign mem_addr_o  = {page, scan_ofs};
  assign mem_wdata_o = rdata;
  assign cnt_upd_o   = done;
  assign cnt_val_o   = {page, ofs};

endmodule

// File: rtl/page_write_sequencer_chk.sv
// Protocol checker, bound onto the top module.
module wpb_checker #(
  parameter int ADDR_W = 11,
  parameter int OFS_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop_i,
  input logic              busy_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              cnt_upd_o,
  input logic [ADDR_W-1:0] cnt_val_o
);

  p_we_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o);

  p_busy_from_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i));

  p_upd_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_upd_o |-> busy_o);

  p_upd_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_upd_o |=> !busy_o);

  p_busy_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !cnt_upd_o) |=> busy_o);

  p_cnt_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(cnt_val_o));

  p_same_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (mem_addr_o[ADDR_W-1:OFS_W] == cnt_val_o[ADDR_W-1:OFS_W]));

  p_ascending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $past(mem_we_o)) |->
      (mem_addr_o[OFS_W-1:0] > $past(mem_addr_o[OFS_W-1:0])));

endmodule

bind page_write_sequencer wpb_checker #(
  .ADDR_W (ADDR_W),
  .OFS_W  (OFS_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stop_i     (stop_i),
  .busy_o     (busy_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .cnt_upd_o  (cnt_upd_o),
  .cnt_val_o  (cnt_val_o)
);

// File: tb/sim_page_write_sequencer.sv
`timescale 1ns/1ps
module sim_page_write_sequencer;

  localparam int WRC = 40;

  logic        clk;
  logic        rst_n;
  logic        start_i, stop_i, wsel_i, addr_load_i, bit_tick_i, byte_wr_i;
  logic [10:0] addr_i;
  logic [7:0]  wbyte_i;
  logic        busy_o, mem_we_o, cnt_upd_o;
  logic [10:0] mem_addr_o, cnt_val_o;
  logic [7:0]  mem_wdata_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  logic [18:0] exp_q[$];

  page_write_sequencer #(.WR_CLKS(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .wsel_i(wsel_i), .addr_load_i(addr_load_i), .addr_i(addr_i),
    .bit_tick_i(bit_tick_i), .byte_wr_i(byte_wr_i), .wbyte_i(wbyte_i),
    .busy_o(busy_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .cnt_upd_o(cnt_upd_o), .cnt_val_o(cnt_val_o)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: each array write is compared to the next expected item.
  always @(negedge clk) begin
    if (rst_n && mem_we_o) begin
      if (exp_q.size() == 0) begin
        check(0, "R4 R5 R9 unexpected write", {mem_addr_o, mem_wdata_o}, 0);
      end else begin
        logic [18:0] it;
        it = exp_q.pop_front();
        check({mem_addr_o, mem_wdata_o} == it, "R2 R3 R9 commit addr/data",
              {mem_addr_o, mem_wdata_o}, it);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_start();  start_i = 1; tick(); start_i = 0; endtask
  task automatic pulse_stop();   stop_i = 1;  tick(); stop_i = 0;  endtask
  task automatic pulse_tick();   bit_tick_i = 1; tick(); bit_tick_i = 0; endtask

  // kind 0: STOP right after the last data ACK; 1: bit tick before STOP;
  // 2: repeated START before STOP. inject: full command during busy.
  task automatic run_cmd(input logic [10:0] a, input int n, input logic [7:0] d0,
                         input int kind, input bit inject);
    logic [7:0] md[16];
    bit         mv[16];
    logic [3:0] o;
    bit         go;
    int         bcnt, ups;
    logic [10:0] upv, expc;
    for (int k = 0; k < 16; k++) begin md[k] = 0; mv[k] = 0; end
    o = a[3:0];
    pulse_start();
    wsel_i = 1; tick(); wsel_i = 0;
    addr_i = a; addr_load_i = 1; tick(); addr_load_i = 0;
    for (int i = 0; i < n; i++) begin
      pulse_tick();
      wbyte_i = d0 + 8'(i); byte_wr_i = 1; tick(); byte_wr_i = 0;
      md[o] = d0 + 8'(i); mv[o] = 1; o = o + 4'd1;
    end
    go   = (kind == 0) && (n > 0);
    expc = {a[10:4], o};
    if (go) for (int k = 0; k < 16; k++) if (mv[k]) exp_q.push_back({a[10:4], 4'(k), md[k]});
    if (kind == 1) pulse_tick();
    if (kind == 2) pulse_start();
    pulse_stop();
    bcnt = 0; ups = 0; upv = 0;
    while (busy_o && bcnt < 4 * WRC) begin
      bcnt++;
      if (cnt_upd_o) begin ups++; upv = cnt_val_o; end
      if (inject) begin
        start_i = (bcnt == 3); wsel_i = (bcnt == 4);
        addr_load_i = (bcnt == 5); addr_i = 11'h7FD;
        byte_wr_i = (bcnt == 6); wbyte_i = 8'h3C;
        stop_i = (bcnt == 7);
      end
      tick();
    end
    start_i = 0; wsel_i = 0; addr_load_i = 0; byte_wr_i = 0; stop_i = 0;
    check(bcnt == (go ? WRC : 0), go ? "R6 busy length" : "R4 R5 no write cycle",
          bcnt, go ? WRC : 0);
    if (go) begin
      check(ups == 1, "R8 one update strobe", ups, 1);
      check(upv == expc, "R8 counter value", upv, expc);
    end
    check(exp_q.size() == 0, "R9 all expected bytes written", exp_q.size(), 0);
    for (int k = 0; k < 5; k++) begin
      tick();
      if (busy_o) begin
        check(0, inject ? "R7 busy traffic ignored" : "R4 quiet after", 1, 0);
        break;
      end
    end
    if (inject) check(!busy_o && cnt_val_o == expc, "R7 counter untouched", cnt_val_o, expc);
  endtask

  initial begin
    rst_n = 0; start_i = 0; stop_i = 0; wsel_i = 0; addr_load_i = 0;
    bit_tick_i = 0; byte_wr_i = 0; addr_i = 0; wbyte_i = 0;
    repeat (3) tick();
    check(!busy_o && !mem_we_o && !cnt_upd_o, "R1 outputs in reset",
          {busy_o, mem_we_o, cnt_upd_o}, 0);
    rst_n = 1;
    tick();
    check(!busy_o && !mem_we_o && !cnt_upd_o, "R1 outputs after reset",
          {busy_o, mem_we_o, cnt_upd_o}, 0);

    run_cmd(11'h123, 1,  8'hA5, 0, 0);  // R2 byte write
    run_cmd(11'h3AE, 4,  8'h10, 0, 0);  // R3 wrap from offset 14
    run_cmd(11'h7F0, 18, 8'h40, 0, 0);  // R3 overflow overwrites offsets 0,1
    run_cmd(11'h255, 3,  8'h77, 1, 0);  // R4 bit tick before STOP
    run_cmd(11'h255, 3,  8'h88, 2, 0);  // R4 repeated START before STOP
    run_cmd(11'h400, 0,  8'h00, 0, 0);  // R5 address-only command
    run_cmd(11'h050, 2,  8'hC1, 0, 1);  // R7 traffic during busy
    run_cmd(11'h00F, 1,  8'h5A, 0, 0);  // R8 counter wraps to offset 0

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL R6 watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule